// File: doc/BRIEF.md
# Write-by-Read Expansion Slot Flash Bridge

This block sits between a host expansion slot that only carries read cycles and a byte-wide parallel flash device. The slot gives the host 16 KB of address space, and its select line is asserted only while the host reads. There is no strobe for writes and no read/write indication. The block splits the slot space into areas. The lowest 4 KB is a direct window onto one 4 KB page of flash. The other areas do not return data. A read that lands in one of them is treated as a command, and the low bits of the address it used are taken as that command's argument.

Programming a flash byte takes two host reads. The first read goes to the data area, and its 8-bit offset is captured as the byte to program. The second read goes to the commit area, and its 12-bit offset is the byte address within the current page. The block then drives the flash address and data and holds write enable low for a fixed number of clocks. Two further areas load the page register one part at a time. The window can therefore show any page of an 8 MB flash. The page register resets to page 0, so the window shows the start of flash, where the boot driver lives.

Top module: `slot_wbr_bridge`

## Requirements
- R1: After reset the page register is 0, flash_we_n, flash_oe_n and flash_ce_n are high while the slot is idle, and host_rdata reads 0xFF.
- R2: A selected read at slot address 0x0000–0x0FFF, with no write pulse in progress, pulls flash_ce_n and flash_oe_n low and drives flash_addr = {page, addr[11:0]}. host_rdata then returns flash_rdata in the same cycle.
- R3: A selected read anywhere outside 0x0000–0x0FFF returns 0xFF on host_rdata and keeps flash_oe_n high.
- R4: A read at 0x1000–0x10FF latches addr[7:0] as the pending program byte and marks that byte as valid.
- R5: A read at 0x3000–0x30FF loads page[7:0] from addr[7:0]. A read at 0x3100–0x31FF loads page[10:8] from addr[2:0]. Each load leaves the other page bits unchanged, and the page register changes on no other event.
- R6: A read at 0x2000–0x2FFF while a valid byte is pending starts a write pulse in the clock after the first clock that samples select. For WE_CYCLES clocks, flash_we_n and flash_ce_n are low, flash_oe_n is high, flash_data_oe is high, flash_addr = {page, addr[11:0]} and flash_wdata holds the pending byte.
- R7: Starting a write pulse clears the pending-valid flag. A commit-area read while no valid byte is pending produces no write pulse.
- R8: Each command acts once per assertion of select. Holding select across many clocks in the commit area produces exactly one write pulse.
- R9: While a write pulse is in progress, a window read returns 0xFF and keeps flash_oe_n high, and a commit-area read is ignored.
- R10: Reads at unmapped addresses (0x1100–0x1FFF, 0x3200–0x3FFF) change neither the page nor the pending byte state, and they return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; slot signals are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Slot select, high during a host read cycle |
| host_addr | input | 14 | Host address within the slot |
| host_rdata | output | 8 | Data returned to the host |
| flash_rdata | input | 8 | Byte read from the flash data bus |
| flash_addr | output | 23 | Flash byte address |
| flash_wdata | output | 8 | Byte driven onto the flash data bus when programming |
| flash_data_oe | output | 1 | High while the block drives flash_wdata |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |

## Verification
The assertions assume that host_sel and host_addr are synchronous to clk and that host_addr stays stable for as long as select is high. Every command read is taken to begin with a clock in which select was low, so that each command produces a fresh rising edge. The bench changes address and select only on falling clock edges. It keeps the address fixed for the whole of each select assertion and leaves at least one clock with select low between accesses. It holds select across many clocks in the commit area to show that a long cycle fires once.

// File: rtl/slot_wbr_pkg.sv
`timescale 1ns/1ps
package slot_wbr_pkg;
  localparam int SLOT_AW = 14;
  localparam int WIN_AW  = 12;
  localparam int PAGE_W  = 11;
  localparam int DW      = 8;
  localparam int FLASH_AW = PAGE_W + WIN_AW;
  localparam int HI_BITS  = PAGE_W - DW;

  typedef enum logic [2:0] {
    AR_NONE, AR_WIN, AR_DATA, AR_COMMIT, AR_PG_LO, AR_PG_HI
  } area_e;

  // Slot address map decode.
  function automatic area_e decode_area(input logic [SLOT_AW-1:0] a);
    area_e r;
    r = AR_NONE;
    if (a[13:12] == 2'd0)      r = AR_WIN;
    else if (a[13:12] == 2'd2) r = AR_COMMIT;
    else if (a[13:8] == 6'h10) r = AR_DATA;
    else if (a[13:8] == 6'h30) r = AR_PG_LO;
    else if (a[13:8] == 6'h31) r = AR_PG_HI;
    return r;
  endfunction

  // Flash byte index from page and in-page offset.
  function automatic logic [FLASH_AW-1:0] flash_index(
      input logic [PAGE_W-1:0] page, input logic [WIN_AW-1:0] off);
    return {page, off};
  endfunction
endpackage

// File: rtl/wbr_decode.sv
`timescale 1ns/1ps
module wbr_decode
  import slot_wbr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic [SLOT_AW-1:0] host_addr,
  output area_e              area,
  output logic               sel_rise,
  output logic               ev_data,
  output logic               ev_commit,
  output logic               ev_pg_lo,
  output logic               ev_pg_hi
);
  logic sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= host_sel;
  end

  always_comb begin
    area      = decode_area(host_addr);
    sel_rise  = host_sel && !sel_q;
    ev_data   = sel_rise && (area == AR_DATA);
    ev_commit = sel_rise && (area == AR_COMMIT);
    ev_pg_lo  = sel_rise && (area == AR_PG_LO);
    ev_pg_hi  = sel_rise && (area == AR_PG_HI);
  end
endmodule

// File: rtl/wbr_cmd_regs.sv
`timescale 1ns/1ps
module wbr_cmd_regs
  import slot_wbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     arg,
  input  logic              ev_data,
  input  logic              ev_pg_lo,
  input  logic              ev_pg_hi,
  input  logic              commit_go,
  output logic [DW-1:0]     data_q,
  output logic              data_valid,
  output logic [PAGE_W-1:0] page_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q     <= '0;
      data_valid <= 1'b0;
    end else if (ev_data) begin
      data_q     <= arg;
      data_valid <= 1'b1;
    end else if (commit_go) begin
      data_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) page_q <= '0;
    else if (ev_pg_lo) page_q[DW-1:0] <= arg;
    else if (ev_pg_hi) page_q[PAGE_W-1:DW] <= arg[HI_BITS-1:0];
  end
endmodule

// File: rtl/wbr_we_timer.sv
`timescale 1ns/1ps
module wbr_we_timer
  import slot_wbr_pkg::*;
#(
  parameter int WE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [FLASH_AW-1:0] addr_in,
  input  logic [DW-1:0]       data_in,
  output logic                busy,
  output logic [FLASH_AW-1:0] wr_addr,
  output logic [DW-1:0]       wr_data
);
  localparam int CNT_W = (WE_CYCLES < 2) ? 1 : $clog2(WE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      cnt     <= CNT_LOAD;
      wr_addr <= addr_in;
      wr_data <= data_in;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/slot_wbr_bridge.sv
`timescale 1ns/1ps
module slot_wbr_bridge
  import slot_wbr_pkg::*;
#(
  parameter int WE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_sel,
  input  logic [13:0]         host_addr,
  output logic [7:0]          host_rdata,
  input  logic [7:0]          flash_rdata,
  output logic [22:0]         flash_addr,
  output logic [7:0]          flash_wdata,
  output logic                flash_data_oe,
  output logic                flash_ce_n,
  output logic                flash_oe_n,
  output logic                flash_we_n
);
  area_e               area;
  logic                sel_rise, ev_data, ev_commit, ev_pg_lo, ev_pg_hi;
  logic                commit_go, busy, data_valid, win_rd;
  logic [DW-1:0]       data_q, wr_data;
  logic [PAGE_W-1:0]   page_q;
  logic [FLASH_AW-1:0] wr_addr, tgt_addr;

  wbr_decode u_dec (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .area(area), .sel_rise(sel_rise), .ev_data(ev_data), .ev_commit(ev_commit),
    .ev_pg_lo(ev_pg_lo), .ev_pg_hi(ev_pg_hi)
  );

  wbr_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .arg(host_addr[DW-1:0]), .ev_data(ev_data),
    .ev_pg_lo(ev_pg_lo), .ev_pg_hi(ev_pg_hi), .commit_go(commit_go),
    .data_q(data_q), .data_valid(data_valid), .page_q(page_q)
  );

  assign commit_go = ev_commit && data_valid && !busy;
  assign tgt_addr  = flash_index(page_q, host_addr[WIN_AW-1:0]);

  wbr_we_timer #(.WE_CYCLES(WE_CYCLES)) u_we (
    .clk(clk), .rst_n(rst_n), .start(commit_go), .addr_in(tgt_addr),
    .data_in(data_q), .busy(busy), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_comb begin
    win_rd        = host_sel && (area == AR_WIN) && !busy;
    flash_addr    = busy ? wr_addr : tgt_addr;
    flash_wdata   = wr_data;
    flash_data_oe = busy;
    flash_we_n    = !busy;
    flash_oe_n    = !win_rd;
    flash_ce_n    = !(busy || win_rd);
    host_rdata    = win_rd ? flash_rdata : 8'hFF;
  end
endmodule

// File: rtl/slot_wbr_bridge_chk.sv
`timescale 1ns/1ps
module slot_wbr_bridge_chk #(
  parameter int WE_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_sel,
  input logic [13:0] host_addr,
  input logic [7:0]  host_rdata,
  input logic        flash_ce_n,
  input logic        flash_oe_n,
  input logic        flash_we_n,
  input logic        sel_rise,
  input logic        commit_go,
  input logic        data_valid,
  input logic        ev_pg_lo,
  input logic        ev_pg_hi,
  input logic [10:0] page_q
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           low_cnt <= '0;
    else if (!flash_we_n) low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1;
    else                  low_cnt <= '0;
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> flash_oe_n);                                              // R6
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> low_cnt == 16'(WE_CYCLES));                         // R6
  AST_WE_START: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> !flash_we_n);                                               // R6
  AST_WIN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_addr[13:12] == 2'b00 && flash_we_n |-> !flash_ce_n && !flash_oe_n); // R2
  AST_CMD_RDATA_FF: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel && host_addr[13:12] != 2'b00 |-> host_rdata == 8'hFF && flash_oe_n); // R3
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_pg_lo || ev_pg_hi) |=> $stable(page_q));                             // R5
  AST_COMMIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |-> data_valid);                                                // R7
  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> !data_valid);                                               // R7
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> !sel_rise);                                                  // R8
  AST_BUSY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_we_n |-> !commit_go);                                              // R9
endmodule

bind slot_wbr_bridge slot_wbr_bridge_chk #(.WE_CYCLES(WE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
  .host_rdata(host_rdata), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
  .flash_we_n(flash_we_n), .sel_rise(sel_rise), .commit_go(commit_go),
  .data_valid(data_valid), .ev_pg_lo(ev_pg_lo), .ev_pg_hi(ev_pg_hi), .page_q(page_q)
);

// File: tb/slot_wbr_bridge_tb.sv
`timescale 1ns/1ps
module slot_wbr_bridge_tb;
  localparam int WE_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic [13:0] host_addr = '0;
  logic [7:0]  host_rdata, flash_rdata, flash_wdata;
  logic [22:0] flash_addr;
  logic        flash_data_oe, flash_ce_n, flash_oe_n, flash_we_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  slot_wbr_bridge #(.WE_CYCLES(WE_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .host_rdata(host_rdata), .flash_rdata(flash_rdata), .flash_addr(flash_addr),
    .flash_wdata(flash_wdata), .flash_data_oe(flash_data_oe), .flash_ce_n(flash_ce_n),
    .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

  // Flash model: erased pattern computed from the address; programming only clears bits.
  logic [7:0] fmem [int];
  logic [7:0] shad [int];

  function automatic logic [7:0] init_byte(int a);
    return 8'(a) ^ 8'(a >> 12) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] mem_rd(int a);
    return fmem.exists(a) ? fmem[a] : init_byte(a);
  endfunction
  function automatic logic [7:0] shad_rd(int a);
    return shad.exists(a) ? shad[a] : init_byte(a);
  endfunction

  always_comb flash_rdata = (!flash_ce_n && !flash_oe_n) ? mem_rd(int'(flash_addr)) : 8'hFF;

  always @(posedge clk)
    if (rst_n && !flash_we_n && flash_data_oe)
      fmem[int'(flash_addr)] = mem_rd(int'(flash_addr)) & flash_wdata;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard: driver pushes expected read data, monitor pops on each sample event.
  typedef struct { logic [7:0] exp; string req; } item_t;
  item_t sbq[$];
  event  smp;

  initial begin
    forever begin
      @(smp);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(host_rdata == it.exp, it.req, int'(host_rdata), int'(it.exp));
      end
    end
  end

  task automatic host_rd(logic [13:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    host_addr = a;
    host_sel  = 1'b1;
    sbq.push_back('{exp, req});
    #1 -> smp;
    @(negedge clk);
    host_sel = 1'b0;
  endtask

  // Commit read held for several clocks; counts write-enable low clocks.
  task automatic commit(logic [13:0] a, bit exp_we, logic [22:0] exp_fa,
                        logic [7:0] exp_d, string req);
    int  lowc;
    bit  first;
    lowc  = 0;
    first = 1'b1;
    @(negedge clk);
    host_addr = a;
    host_sel  = 1'b1;
    for (int i = 0; i < WE_CYCLES + 6; i++) begin
      @(negedge clk);
      #1;
      if (!flash_we_n) begin
        lowc++;
        if (first) begin
          first = 1'b0;
          chk(flash_addr == exp_fa, req, int'(flash_addr), int'(exp_fa));
          chk(flash_wdata == exp_d, req, int'(flash_wdata), int'(exp_d));
          chk(flash_oe_n && !flash_ce_n && flash_data_oe, req,
              int'({flash_oe_n, flash_ce_n, flash_data_oe}), 3'b101);
        end
      end
    end
    host_sel = 1'b0;
    chk(lowc == (exp_we ? WE_CYCLES : 0), req, lowc, exp_we ? WE_CYCLES : 0);
    if (exp_we) shad[int'(exp_fa)] = shad_rd(int'(exp_fa)) & exp_d;
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [22:0] fa;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(flash_we_n && flash_oe_n && flash_ce_n, "R1 strobes idle",
        int'({flash_we_n, flash_oe_n, flash_ce_n}), 3'b111);
    chk(host_rdata == 8'hFF, "R1 idle rdata", int'(host_rdata), 8'hFF);

    // R1/R2 window reads on page 0
    host_rd(14'h0000, shad_rd(0), "R1 R2 page0 first byte");
    host_rd(14'h0FFF, shad_rd('hFFF), "R2 page0 last byte");

    // R2 window strobes
    @(negedge clk);
    host_addr = 14'h0ABC;
    host_sel  = 1'b1;
    #1;
    chk(!flash_ce_n && !flash_oe_n && flash_addr == 23'h000ABC, "R2 strobes and address",
        int'(flash_addr), 'hABC);
    @(negedge clk);
    host_sel = 1'b0;

    // R3/R4 data latch area returns FF, with OE high
    @(negedge clk);
    host_addr = 14'h1005;
    host_sel  = 1'b1;
    #1;
    chk(host_rdata == 8'hFF && flash_oe_n, "R3 R4 data area read", int'(host_rdata), 8'hFF);
    @(negedge clk);
    host_sel = 1'b0;

    // R5 page load: page = 0x507
    host_rd(14'h3007, 8'hFF, "R3 R5 page low load");
    host_rd(14'h3105, 8'hFF, "R3 R5 page high load");
    fa = {11'h507, 12'h123};
    host_rd(14'h0123, shad_rd(int'(fa)), "R5 window after page 0x507");
    host_rd(14'h3009, 8'hFF, "R5 second low load");
    fa = {11'h509, 12'h123};
    host_rd(14'h0123, shad_rd(int'(fa)), "R5 high bits kept, page 0x509");

    // R4/R6/R8 commit (pending byte 0x3C)
    host_rd(14'h103C, 8'hFF, "R4 latch 0x3C");
    commit(14'h2456, 1'b1, {11'h509, 12'h456}, 8'h3C, "R6 R8 commit pulse");
    fa = {11'h509, 12'h456};
    host_rd(14'h0456, shad_rd(int'(fa)), "R6 programmed byte visible");

    // R7 stale commit ignored
    commit(14'h2457, 1'b0, '0, '0, "R7 stale commit no pulse");
    fa = {11'h509, 12'h457};
    host_rd(14'h0457, shad_rd(int'(fa)), "R7 stale target unchanged");

    // R10 unmapped reads
    host_rd(14'h1200, 8'hFF, "R10 unmapped 0x1200");
    host_rd(14'h3300, 8'hFF, "R10 unmapped 0x3300");
    host_rd(14'h3FFF, 8'hFF, "R10 unmapped 0x3FFF");
    fa = {11'h509, 12'h000};
    host_rd(14'h0000, shad_rd(int'(fa)), "R10 page unchanged");
    commit(14'h2458, 1'b0, '0, '0, "R10 no pending byte set");

    // R9 window read during a write pulse
    host_rd(14'h100F, 8'hFF, "R4 latch 0x0F");
    @(negedge clk);
    host_addr = 14'h2010;
    host_sel  = 1'b1;
    @(negedge clk);
    host_sel = 1'b0;
    @(negedge clk);
    host_addr = 14'h0010;
    host_sel  = 1'b1;
    #1;
    chk(!flash_we_n, "R9 pulse active", int'(flash_we_n), 0);
    chk(host_rdata == 8'hFF && flash_oe_n, "R9 window blocked during pulse",
        int'(host_rdata), 8'hFF);
    repeat (WE_CYCLES + 2) @(negedge clk);
    host_sel = 1'b0;
    fa = {11'h509, 12'h010};
    shad[int'(fa)] = shad_rd(int'(fa)) & 8'h0F;
    host_rd(14'h0010, shad_rd(int'(fa)), "R6 R9 second programmed byte");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule